// File: doc/BRIEF.md
# Asynchronous Serial Adapter

This block is a byte-wide asynchronous serial port that sits behind a simple CPU bus. The bus reaches two locations, chosen by `addrIn`. At location 0 a write sets the control byte and a read returns the status byte. At location 1 a write loads the transmit holding register and a read returns the receive holding register. Bus accesses are single-cycle strobes. Read data is combinational while `selIn` is high and `wrIn` is low. A read of location 1 clears the receive flags at the clock edge that ends the access.

The control byte has four fields:

- bits [1:0] select the bit-clock divide ratio, or hold the block in master reset;
- bits [4:2] select one of eight word formats;
- bits [6:5] are a transmit-control field that sets the RTS level, enables the transmit interrupt, or forces a break;
- bit 7 enables the receive interrupt.

Each direction has one holding register in front of its shift engine. The receiver samples each bit at mid-bit and checks parity, the first stop bit and overrun. An active-low interrupt line and a status bit report pending work.

Top module: `sio_adapter`

## Requirements
- R1: Control bits [1:0] = 0, 1, 2 make every serial bit last 1, DIV_MID (16) or DIV_HI (64) clock cycles, for both transmit and receive.
- R2: Control bits [1:0] = 3 is master reset. Both engines are held idle, receive-full, overrun, framing error and parity error are cleared, and transmit-empty is set. Writes to location 1 are ignored. The control byte resets to 0x03, so the status byte after reset is 0x02 when carrier detect and clear-to-send are low.
- R3: Control bits [4:2] give the word format as data bits / parity / stop bits:
  - 0 = 7/even/2
  - 1 = 7/odd/2
  - 2 = 7/even/1
  - 3 = 7/odd/1
  - 4 = 8/none/2
  - 5 = 8/none/1
  - 6 = 8/even/1
  - 7 = 8/odd/1

  Even parity makes the count of ones over the data and parity bits even; odd parity makes it odd.
- R4: A transmitted frame is one low start bit, the data bits LSB first, the parity bit if the format has one, and then high stop bits. The line idles high.
- R5: Control bits [6:5]:
  - 0: RTS low, transmit interrupt off.
  - 1: RTS low, transmit interrupt on.
  - 2: RTS high, transmit interrupt off.
  - 3: RTS low, transmit interrupt off, and the transmit line held low for as long as the field stays 3.
- R6: Interrupt request = (control bit 7 AND (receive-full OR overrun)) OR (field [6:5] = 1 AND transmit-empty). It is shown in status bit 7 and driven active low on `irqN`.
- R7: Status bit order, bit 0 first:
  - receive-full
  - transmit-empty
  - carrier detect (`dcdIn` level)
  - clear-to-send (`ctsIn` level)
  - framing error
  - overrun
  - parity error
  - interrupt request
- R8: Reading location 1 clears receive-full, overrun, framing error and parity error. Writing location 1 clears transmit-empty until the byte moves into the transmit shifter.
- R9: When a character completes while receive-full is still set, overrun is set and the held character and its error flags are kept.
- R10: With divide 16 or 64, the start bit is re-checked at mid-bit. A low pulse shorter than half a bit is dropped as a false start, and receive-full stays clear.
- R11: The parity error flag is set when the received parity bit does not match the format. The framing error flag is set when the first stop bit is sampled low. Both are latched with the character.
- R12: In a 7-bit format, bit 7 of the receive holding register reads 0 and the transmitter sends only data bits 0 to 6.
- R13: While `ctsIn` is high, no new frame starts. The held byte stays held, with transmit-empty clear, until `ctsIn` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selIn | input | 1 | Bus access strobe for this cycle |
| wrIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | 1 | 0 = control/status, 1 = transmit/receive data |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, zero when there is no read |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| ctsIn | input | 1 | Clear-to-send level; high inhibits transmission |
| dcdIn | input | 1 | Carrier detect level, reported in status |
| rtsOut | output | 1 | RTS level set by the transmit-control field |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The bit-timing assertion assumes that the control byte is not rewritten while a frame is on the transmit line. A change of divide ratio in the middle of a frame would move the bit boundaries.

The stimulus therefore changes the control byte only before a transmit-data write, or after the captured frame has ended.

The receive line is driven with whole bit periods that begin on falling clock edges. Each read or write strobe lasts exactly one cycle, so every received frame is the aligned, full-length waveform that the overrun and read-clear assertions expect.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic       clr;     // master reset held
    logic [1:0] divSel;  // divide select
    logic [2:0] fmt;     // word format code
    logic       brk;     // force line low
    logic       txLoad;  // move holding byte into shifter
    logic [7:0] txByte;  // holding byte
  } sioStrobe_t;

  typedef struct packed {
    logic wide;     // 8 data bits
    logic parEn;
    logic parOdd;
    logic twoStop;
  } wordFmt_t;

  function automatic wordFmt_t decodeFmt(input logic [2:0] code);
    wordFmt_t f;
    f.wide    = code[2];
    f.parEn   = !code[2] || code[1];
    f.parOdd  = code[0];
    f.twoStop = (code[2:1] == 2'b00) || (code == 3'd4);
    return f;
  endfunction

endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  sioStrobe_t stb,
  input  logic       ctsIn,
  input  logic       rxIn,
  output logic       txOut,
  output logic       txReady,
  output logic       rxDone,
  output logic [7:0] rxByte,
  output logic       rxFrameErr,
  output logic       rxParErr
);

  localparam int CNT_W   = $clog2(DIV_HI) + 1;
  localparam int FRAME_W = 12;
  localparam int BIT_W   = 4;
  localparam int RXSH_W  = 10;

  wordFmt_t fmt;
  assign fmt = decodeFmt(stb.fmt);

  logic [CNT_W-1:0] period;
  always_comb begin
    case (stb.divSel)
      2'd1:    period = CNT_W'(DIV_MID);
      2'd2:    period = CNT_W'(DIV_HI);
      default: period = CNT_W'(1);
    endcase
  end

  // ---------------- transmit engine ----------------
  logic               txBusy;
  logic [FRAME_W-1:0] txFrame;
  logic [BIT_W-1:0]   txLeft;
  logic [CNT_W-1:0]   txCnt;
  logic [FRAME_W-1:0] newFrame;
  logic [BIT_W-1:0]   newLen;

  always_comb begin
    logic [7:0] d;
    logic       p;
    d = stb.txByte;
    if (!fmt.wide) d[7] = 1'b0;
    p = (^d) ^ fmt.parOdd;
    newFrame    = '1;
    newFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (fmt.wide || i < 7) newFrame[i+1] = d[i];
    end
    if (fmt.parEn) newFrame[fmt.wide ? 9 : 8] = p;
    newLen = BIT_W'(fmt.wide ? 10 : 9) + BIT_W'(fmt.parEn) + BIT_W'(fmt.twoStop);
  end

  assign txReady = !txBusy && !ctsIn && !stb.brk && !stb.clr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txFrame <= '1;
      txLeft  <= '0;
      txCnt   <= '0;
    end else if (stb.clr) begin
      txBusy  <= 1'b0;
      txFrame <= '1;
      txLeft  <= '0;
      txCnt   <= '0;
    end else if (stb.txLoad) begin
      txBusy  <= 1'b1;
      txFrame <= newFrame;
      txLeft  <= newLen;
      txCnt   <= '0;
    end else if (txBusy) begin
      if (txCnt == period - 1'b1) begin
        txCnt   <= '0;
        txFrame <= {1'b1, txFrame[FRAME_W-1:1]};
        txLeft  <= txLeft - 1'b1;
        if (txLeft == BIT_W'(1)) txBusy <= 1'b0;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txOut = stb.brk ? 1'b0 : (txBusy ? txFrame[0] : 1'b1);

  // ---------------- receive engine ----------------
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

  logic              rxMeta, rxS;
  rxState_t          rxState;
  logic [CNT_W-1:0]  rxCnt;
  logic [BIT_W-1:0]  rxIdx;
  logic [RXSH_W-1:0] rxSh;
  logic [BIT_W-1:0]  rxLastIdx;
  logic              parBit;

  assign rxLastIdx = BIT_W'(fmt.wide ? 8 : 7) + BIT_W'(fmt.parEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta  <= 1'b1;
      rxS     <= 1'b1;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
      rxSh    <= '1;
      rxDone  <= 1'b0;
    end else begin
      rxMeta <= rxIn;
      rxS    <= rxMeta;
      rxDone <= 1'b0;
      if (stb.clr) begin
        rxState <= RX_IDLE;
        rxCnt   <= '0;
        rxIdx   <= '0;
      end else begin
        case (rxState)
          RX_IDLE: begin
            if (!rxS) begin
              rxCnt   <= '0;
              rxIdx   <= '0;
              rxState <= (period == CNT_W'(1)) ? RX_BITS : RX_START;
            end
          end
          RX_START: begin
            if (rxCnt == (period >> 1) - 1'b1) begin
              rxCnt   <= '0;
              rxState <= rxS ? RX_IDLE : RX_BITS;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
          default: begin
            if (rxCnt == period - 1'b1) begin
              rxCnt       <= '0;
              rxSh[rxIdx] <= rxS;
              rxIdx       <= rxIdx + 1'b1;
              if (rxIdx == rxLastIdx) begin
                rxDone  <= 1'b1;
                rxState <= RX_IDLE;
              end
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign rxByte     = fmt.wide ? rxSh[7:0] : {1'b0, rxSh[6:0]};
  assign parBit     = fmt.wide ? rxSh[8] : rxSh[7];
  assign rxParErr   = fmt.parEn && ((^rxByte) ^ parBit ^ fmt.parOdd);
  assign rxFrameErr = !rxSh[rxLastIdx];

  // R13
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctsIn && !txBusy |=> !txBusy);

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBusy && !stb.clr && !stb.brk && (txCnt != period - 1'b1)
    |=> stb.brk || stb.clr || $stable(txOut));

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selIn,
  input  logic       wrIn,
  input  logic       addrIn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       ctsIn,
  input  logic       dcdIn,
  input  logic       txReady,
  input  logic       rxDone,
  input  logic [7:0] rxByte,
  input  logic       rxFrameErr,
  input  logic       rxParErr,
  output sioStrobe_t stb,
  output logic       rtsOut,
  output logic       irqN
);

  logic [7:0] ctrlReg, txHold, rxHold;
  logic       rxFull, txEmpty, ovr, fe, pe;
  logic       wrCtrl, wrTx, rdRx, clr, txLoad, irqOn;
  logic [1:0] txCtl;
  logic [7:0] status;

  assign wrCtrl = selIn && wrIn && !addrIn;
  assign wrTx   = selIn && wrIn && addrIn;
  assign rdRx   = selIn && !wrIn && addrIn;
  assign clr    = (ctrlReg[1:0] == 2'b11);
  assign txCtl  = ctrlReg[6:5];
  assign txLoad = !txEmpty && txReady;

  assign stb.clr    = clr;
  assign stb.divSel = ctrlReg[1:0];
  assign stb.fmt    = ctrlReg[4:2];
  assign stb.brk    = (txCtl == 2'b11);
  assign stb.txLoad = txLoad;
  assign stb.txByte = txHold;

  assign irqOn  = (ctrlReg[7] && (rxFull || ovr)) || ((txCtl == 2'b01) && txEmpty);
  assign status = {irqOn, pe, ovr, fe, ctsIn, dcdIn, txEmpty, rxFull};
  assign rdData = (selIn && !wrIn) ? (addrIn ? rxHold : status) : 8'h00;
  assign rtsOut = (txCtl == 2'b10);
  assign irqN   = !irqOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= 8'h03;
      txHold  <= 8'h00;
      rxHold  <= 8'h00;
      rxFull  <= 1'b0;
      txEmpty <= 1'b1;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData;
      if (clr) begin
        rxFull  <= 1'b0;
        ovr     <= 1'b0;
        fe      <= 1'b0;
        pe      <= 1'b0;
        txEmpty <= 1'b1;
      end else begin
        if (wrTx) begin
          txHold  <= wrData;
          txEmpty <= 1'b0;
        end else if (txLoad) begin
          txEmpty <= 1'b1;
        end
        if (rxDone) begin
          if (rxFull && !rdRx) begin
            ovr <= 1'b1;
          end else begin
            rxHold <= rxByte;
            rxFull <= 1'b1;
            ovr    <= 1'b0;
            fe     <= rxFrameErr;
            pe     <= rxParErr;
          end
        end else if (rdRx) begin
          rxFull <= 1'b0;
          ovr    <= 1'b0;
          fe     <= 1'b0;
          pe     <= 1'b0;
        end
      end
    end
  end

  // R9
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rxFull && !rdRx && !clr |=> ovr && $stable(rxHold));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdRx && !rxDone |=> !rxFull && !ovr);

  // R2
  mreset_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> txEmpty && !rxFull && !ovr);

  // R6
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) && ctrlReg[7] |-> !irqN);

endmodule

// File: rtl/sio_adapter.sv
module sio_adapter
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selIn,
  input  logic       wrIn,
  input  logic       addrIn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxIn,
  output logic       txOut,
  input  logic       ctsIn,
  input  logic       dcdIn,
  output logic       rtsOut,
  output logic       irqN
);

  sioStrobe_t stb;
  logic       txReady, rxDone, rxFrameErr, rxParErr;
  logic [7:0] rxByte;

  sio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .wrIn(wrIn), .addrIn(addrIn),
    .wrData(wrData), .rdData(rdData), .ctsIn(ctsIn), .dcdIn(dcdIn),
    .txReady(txReady), .rxDone(rxDone), .rxByte(rxByte),
    .rxFrameErr(rxFrameErr), .rxParErr(rxParErr), .stb(stb),
    .rtsOut(rtsOut), .irqN(irqN)
  );

  sio_datapath #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctsIn(ctsIn), .rxIn(rxIn),
    .txOut(txOut), .txReady(txReady), .rxDone(rxDone), .rxByte(rxByte),
    .rxFrameErr(rxFrameErr), .rxParErr(rxParErr)
  );

endmodule

// File: tb/sio_adapter_test.sv
`timescale 1ns/1ps
module sio_adapter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selIn = 1'b0, wrIn = 1'b0, addrIn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       rxIn = 1'b1, ctsIn = 1'b0, dcdIn = 1'b0;
  logic       txOut, rtsOut, irqN;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  sio_adapter uut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .wrIn(wrIn), .addrIn(addrIn),
    .wrData(wrData), .rdData(rdData), .rxIn(rxIn), .txOut(txOut),
    .ctsIn(ctsIn), .dcdIn(dcdIn), .rtsOut(rtsOut), .irqN(irqN)
  );

  // {control byte, data byte}
  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h14A5, 16'h013C, 16'h1D81, 16'h1A5A,
    16'h0CFF, 16'h1100, 16'h05C3, 16'h086E
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int divOf(input logic [7:0] c);
    case (c[1:0])
      2'd1:    return 16;
      2'd2:    return 64;
      default: return 1;
    endcase
  endfunction

  // Frame from the word-format rules (R3, R4)
  function automatic void mkFrame(input logic [2:0] code, input logic [7:0] d,
                                  output logic [11:0] fr, output int len);
    int nb, par, ns;
    logic pb;
    case (code)
      3'd0: begin nb = 7; par = 1; ns = 2; end
      3'd1: begin nb = 7; par = 2; ns = 2; end
      3'd2: begin nb = 7; par = 1; ns = 1; end
      3'd3: begin nb = 7; par = 2; ns = 1; end
      3'd4: begin nb = 8; par = 0; ns = 2; end
      3'd5: begin nb = 8; par = 0; ns = 1; end
      3'd6: begin nb = 8; par = 1; ns = 1; end
      default: begin nb = 8; par = 2; ns = 1; end
    endcase
    fr = '1;
    fr[0] = 1'b0;
    pb = 1'b0;
    for (int i = 0; i < nb; i++) begin
      fr[1+i] = d[i];
      pb = pb ^ d[i];
    end
    len = 1 + nb;
    if (par != 0) begin
      fr[len] = (par == 2) ? ~pb : pb;
      len++;
    end
    len += ns;
  endfunction

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    selIn = 1'b1; wrIn = 1'b1; addrIn = a; wrData = d;
    @(negedge clk);
    selIn = 1'b0; wrIn = 1'b0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    @(negedge clk);
    selIn = 1'b1; wrIn = 1'b0; addrIn = a;
    #1 d = rdData;
    @(negedge clk);
    selIn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] c, input logic [7:0] d, input logic [11:0] flip);
    logic [11:0] fr;
    int len, p;
    p = divOf(c);
    mkFrame(c[4:2], d, fr, len);
    fr = fr ^ flip;
    @(negedge clk);
    for (int b = 0; b < len; b++) begin
      rxIn = fr[b];
      repeat (p) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (p + 4) @(negedge clk);
  endtask

  task automatic captureTx(input int p, input int len, output logic [11:0] fr);
    int w;
    fr = '1;
    w = 0;
    @(negedge clk);
    while (txOut !== 1'b0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 3000) begin
      chk("R4 start bit seen", 0, 1);
      return;
    end
    repeat (p / 2) @(negedge clk);
    fr[0] = txOut;
    for (int k = 1; k < len; k++) begin
      repeat (p) @(negedge clk);
      fr[k] = txOut;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [11:0] ef, got;
    int len, cnt;
    logic sawLow;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    busRead(1'b0, rd);
    chk("R2 reset status", rd, 8'h02);
    chk("R2 reset irqN", irqN, 1'b1);
    chk("R4 idle line high", txOut, 1'b1);
    chk("R5 reset rts", rtsOut, 1'b0);

    // Vector table: transmit frame and receive of the same byte
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c, d;
      int p;
      c = VEC[v][15:8];
      d = VEC[v][7:0];
      p = divOf(c);
      busWrite(1'b0, 8'h03);
      busWrite(1'b0, c);
      busWrite(1'b1, d);
      mkFrame(c[4:2], d, ef, len);
      captureTx(p, len, got);
      chk("R1 R3 R4 tx frame", got, ef);
      sendRx(c, d, 12'h000);
      busRead(1'b0, rd);
      chk("R7 R11 rx status", rd & 8'h51, 8'h01);
      busRead(1'b1, rd);
      chk("R12 rx data", rd, c[4] ? d : {1'b0, d[6:0]});
      busRead(1'b0, rd);
      chk("R8 full cleared by read", rd[0], 1'b0);
    end

    // R1 divide by 16: start bit plus eight zero bits last 144 cycles
    busWrite(1'b0, 8'h03);
    busWrite(1'b0, 8'h15);
    busWrite(1'b1, 8'h00);
    cnt = 0;
    @(negedge clk);
    while (txOut !== 1'b0 && cnt < 100) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (txOut === 1'b0 && cnt < 2000) begin @(negedge clk); cnt++; end
    chk("R1 low time div16", cnt, 144);
    repeat (40) @(negedge clk);

    // R7 carrier detect and clear-to-send positions
    dcdIn = 1'b1;
    busRead(1'b0, rd);
    chk("R7 dcd bit2", rd & 8'h0C, 8'h04);
    ctsIn = 1'b1;
    busRead(1'b0, rd);
    chk("R7 cts bit3", rd & 8'h0C, 8'h0C);
    dcdIn = 1'b0;

    // R13 CTS inhibits transmission
    busWrite(1'b1, 8'h96);
    sawLow = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (txOut !== 1'b1) sawLow = 1'b1;
    end
    chk("R13 line idle while cts high", sawLow, 1'b0);
    busRead(1'b0, rd);
    chk("R13 R8 tx empty clear while held", rd[1], 1'b0);
    ctsIn = 1'b0;
    mkFrame(3'd5, 8'h96, ef, len);
    captureTx(16, len, got);
    chk("R13 frame after cts low", got, ef);
    repeat (40) @(negedge clk);

    // R5 break, RTS, TX interrupt
    busWrite(1'b0, 8'h75);
    repeat (3) @(negedge clk);
    sawLow = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (txOut !== 1'b0) sawLow = 1'b0;
    end
    chk("R5 break holds line low", sawLow, 1'b1);
    chk("R5 break rts low", rtsOut, 1'b0);
    busWrite(1'b0, 8'h55);
    chk("R5 rts high", rtsOut, 1'b1);
    chk("R4 line high after break", txOut, 1'b1);
    busWrite(1'b0, 8'h35);
    chk("R6 tx irq on empty", irqN, 1'b0);
    busRead(1'b0, rd);
    chk("R6 status irq bit", rd[7], 1'b1);
    busWrite(1'b0, 8'h15);
    chk("R6 tx irq off", irqN, 1'b1);

    // R9 overrun keeps the first character
    sendRx(8'h15, 8'h11, 12'h000);
    sendRx(8'h15, 8'h22, 12'h000);
    busRead(1'b0, rd);
    chk("R9 full and overrun", rd & 8'h21, 8'h21);
    busRead(1'b1, rd);
    chk("R9 older byte kept", rd, 8'h11);
    busRead(1'b0, rd);
    chk("R8 read clears overrun", rd & 8'h21, 8'h00);

    // R11 parity error (format 6, parity bit at frame index 9)
    busWrite(1'b0, 8'h19);
    sendRx(8'h19, 8'h0F, 12'h200);
    busRead(1'b0, rd);
    chk("R11 parity error", rd & 8'h51, 8'h41);
    busRead(1'b1, rd);

    // R11 framing error (format 5, stop bit at frame index 9)
    busWrite(1'b0, 8'h15);
    sendRx(8'h15, 8'h3C, 12'h200);
    busRead(1'b0, rd);
    chk("R11 framing error", rd & 8'h51, 8'h11);
    busRead(1'b1, rd);
    chk("R11 data with framing error", rd, 8'h3C);

    // R10 false start rejected, receiver still works afterwards
    @(negedge clk);
    rxIn = 1'b0;
    repeat (4) @(negedge clk);
    rxIn = 1'b1;
    repeat (100) @(negedge clk);
    busRead(1'b0, rd);
    chk("R10 short pulse ignored", rd[0], 1'b0);
    sendRx(8'h15, 8'h5C, 12'h000);
    busRead(1'b1, rd);
    chk("R10 next byte received", rd, 8'h5C);

    // R6 receive interrupt
    busWrite(1'b0, 8'h95);
    chk("R6 no irq when empty", irqN, 1'b1);
    sendRx(8'h95, 8'hE7, 12'h000);
    chk("R6 rx irq active low", irqN, 1'b0);
    busRead(1'b1, rd);
    chk("R6 irq released after read", irqN, 1'b1);

    // R2 master reset clears pending flags
    busWrite(1'b0, 8'h15);
    sendRx(8'h15, 8'h44, 12'h200);
    sendRx(8'h15, 8'h45, 12'h000);
    busWrite(1'b0, 8'h03);
    busRead(1'b0, rd);
    chk("R2 master reset status", rd, 8'h02);
    busWrite(1'b1, 8'hAA);
    busRead(1'b0, rd);
    chk("R2 data write ignored in master reset", rd[1], 1'b1);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule